// File: doc/BRIEF.md
# Register-window bus slave with interrupter

This block is a slave on a VME64 backplane. It opens a 1 KiB window of 32-bit registers to a bus master. The backplane is modelled as plain active-low signals. The address modifier selects one of three address widths, and the slave answers single 32-bit, 16-bit or byte data cycles by pulling the data-acknowledge line low. The strobes are brought through two-flop synchronisers into the logic clock domain. Acknowledge then follows quickly enough to meet a 100 ns budget at a 50 MHz logic clock. Acknowledge stays low until the master has released both data strobes.

The window holds a control word, a status/ID word and general scratch words. A one-cycle hardware event input raises an interrupt request. The request appears on the backplane interrupt line given by a software-written level, and only when software has set an enable bit. When an acknowledge cycle reaches this slave through the daisy chain, the slave answers with the 32-bit status/ID if the acknowledged level is its own. Otherwise it passes the chain on to the next slot. The request is not withdrawn by the acknowledge cycle. It is withdrawn when software next accesses any register in the window.

Top module: `vme_reg_slave`

## Requirements
- R1: Only address-modifier codes 0x09, 0x0D, 0x39, 0x3D, 0x29 and 0x2D are answered. Any other code never produces an acknowledge and leaves every register unchanged.
- R2: Codes 0x09/0x0D use 32-bit addresses and compare address bits 31..10 with base bits 21..0. Codes 0x39/0x3D use 24-bit addresses and compare bits 23..10 with base bits 13..0. Codes 0x29/0x2D use 16-bit addresses and compare bits 15..10 with base bits 5..0. A mismatch is not answered.
- R3: With parameter USE_JUMPER=1 the base comes from the jumper_base input. With USE_JUMPER=0 it is the FIXED_BASE parameter, and jumper_base is ignored.
- R4: A cycle with LWORD low and both strobes low is a 32-bit access of the register at word index address[9:2], carried on data[31:0].
- R5: Any other cycle is a 16-bit or byte access on data[15:0]. Address bit 1 = 0 selects register bits 31..16, and address bit 1 = 1 selects bits 15..0. The DS1 strobe writes the upper byte of that half and DS0 writes the lower byte. A read returns the whole selected half.
- R6: Acknowledge goes low no more than 5 clock cycles after the data strobe falls. It is held until both strobes are high again, and then released. Data is driven only while acknowledge is low.
- R7: Word 0 is control: bits 2..0 are the level and bit 3 is the enable. It reads back as {pending, 27 zeros, enable, level}. Word 1 is the status/ID. Words 2..NREGS-1 are scratch. Higher words in the window are acknowledged, read as 0 and ignore writes.
- R8: An event pulse sets a pending flag. IRQ line L is low exactly when the flag is set, the enable is 1 and the level equals L. Level 0, or enable 0, drives no line.
- R9: In an acknowledge cycle with IACKIN low, the slave answers with the status/ID when its request is active and address bits 3..1 equal its level. Otherwise it drives IACKOUT low until AS is released. With IACKIN high it does neither.
- R10: Any answered register access clears the pending flag, while the acknowledge cycle does not. An event in the same cycle as the access leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low reset |
| as_n | input | 1 | Address strobe |
| ds0_n | input | 1 | Data strobe, odd byte |
| ds1_n | input | 1 | Data strobe, even byte |
| write_n | input | 1 | Low for a write cycle |
| lword_n | input | 1 | Low together with both strobes for a 32-bit cycle |
| am | input | 6 | Address-modifier code |
| addr | input | 31 | Address bits 31..1 |
| data_in | input | 32 | Write data from the bus |
| data_out | output | 32 | Read data or status/ID |
| data_oe | output | 1 | Read data is being driven |
| dtack_n | output | 1 | Data acknowledge |
| iack_n | input | 1 | Low during an interrupt-acknowledge cycle |
| iackin_n | input | 1 | Daisy-chain acknowledge input |
| iackout_n | output | 1 | Daisy-chain acknowledge output |
| irq_n | output | 7 | Interrupt request lines 7..1 |
| jumper_base | input | 22 | Base-address jumpers |
| irq_event | input | 1 | One-cycle interrupt source |

## Verification
The event input and a software register access can land in the same clock edge. One sets the pending flag and the other clears it. The bench times the event pulse so that it is high exactly on the edge where the access is taken. It then judges the result at the interrupt lines: the request must still be asserted, and a second access without an event must drop it. The acknowledge cycle and the pending request meet as well. The bench confirms that answering the acknowledge leaves the request in place until a register read, and that the read returns the pending bit as it stood before the clear.

// File: rtl/vme_slave_pkg.sv
package vme_slave_pkg;

  typedef enum logic [1:0] {SP_NONE, SP_A32, SP_A24, SP_A16} space_e;

  function automatic space_e am_space(input logic [5:0] am);
    case (am)
      6'h09, 6'h0D: return SP_A32;
      6'h39, 6'h3D: return SP_A24;
      6'h29, 6'h2D: return SP_A16;
      default:      return SP_NONE;
    endcase
  endfunction

  function automatic logic base_hit(input space_e sp, input logic [31:10] a,
                                    input logic [21:0] base);
    case (sp)
      SP_A32:  return a[31:10] == base;
      SP_A24:  return a[23:10] == base[13:0];
      SP_A16:  return a[15:10] == base[5:0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] lane_enables(input logic d32, input logic ds1_n,
                                              input logic ds0_n, input logic a1);
    if (d32) return 4'b1111;
    if (!a1) return {~ds1_n, ~ds0_n, 2'b00};
    return {2'b00, ~ds1_n, ~ds0_n};
  endfunction

  function automatic logic [31:0] spread_write(input logic [31:0] d, input logic d32);
    return d32 ? d : {d[15:0], d[15:0]};
  endfunction

  function automatic logic [31:0] place_read(input logic [31:0] w, input logic d32,
                                             input logic a1);
    if (d32) return w;
    return a1 ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
  endfunction

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
    return r;
  endfunction

endpackage

// File: rtl/vme_sync.sv
module vme_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      q      <= '1;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/vme_cycle_ctrl.sv
module vme_cycle_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic as_s,
  input  logic ds0_s,
  input  logic ds1_s,
  input  logic write_s,
  input  logic iackin_s,
  input  logic iack_n,
  input  logic hit,
  input  logic iack_match,
  output logic access_stb,
  output logic iack_stb,
  output logic dtack_n,
  output logic iackout_n,
  output logic data_oe
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_PASS} st_e;
  st_e  state_q;
  logic strobe_on, pass_go;

  always_comb begin
    strobe_on  = !as_s && (!ds0_s || !ds1_s);
    access_stb = (state_q == ST_IDLE) && strobe_on && iack_n && hit;
    iack_stb   = (state_q == ST_IDLE) && strobe_on && !iack_n && !iackin_s && iack_match;
    pass_go    = (state_q == ST_IDLE) && strobe_on && !iack_n && !iackin_s && !iack_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      dtack_n   <= 1'b1;
      iackout_n <= 1'b1;
      data_oe   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (access_stb || iack_stb) begin
            state_q <= ST_ACK;
            dtack_n <= 1'b0;
            data_oe <= iack_stb || write_s;
          end else if (pass_go) begin
            state_q   <= ST_PASS;
            iackout_n <= 1'b0;
          end
        end
        ST_ACK: begin
          if (ds0_s && ds1_s) begin
            state_q <= ST_IDLE;
            dtack_n <= 1'b1;
            data_oe <= 1'b0;
          end
        end
        default: begin
          if (as_s || iackin_s) begin
            state_q   <= ST_IDLE;
            iackout_n <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vme_regfile.sv
module vme_regfile
  import vme_slave_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        access_stb,
  input  logic        iack_stb,
  input  logic        wr_en,
  input  logic [7:0]  word_idx,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        d32,
  input  logic        a1,
  input  logic        irq_event,
  output logic [31:0] rdata,
  output logic [2:0]  level,
  output logic        ien,
  output logic        pending
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [31:0]   mem [NREGS];
  logic          in_range;
  logic [IW-1:0] lo;
  logic [31:0]   rd_word;

  assign in_range = (32'(word_idx) < NREGS);
  assign lo       = word_idx[IW-1:0];
  assign level    = mem[0][2:0];
  assign ien      = mem[0][3];

  always_comb begin
    rd_word = '0;
    if (in_range) rd_word = mem[lo];
    if (in_range && lo == '0) rd_word = {pending, 27'b0, mem[0][3:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
      pending <= 1'b0;
      rdata   <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++)
        if (access_stb && wr_en && in_range && lo == IW'(i))
          mem[i] <= merge_bytes(mem[i], wdata, be) & ((i == 0) ? 32'h0000_000F : 32'hFFFF_FFFF);
      if (access_stb && !wr_en) rdata <= place_read(rd_word, d32, a1);
      if (iack_stb) rdata <= mem[1];
      pending <= irq_event || (pending && !access_stb);
    end
  end
endmodule

// File: rtl/vme_reg_slave.sv
module vme_reg_slave
  import vme_slave_pkg::*;
#(
  parameter int          NREGS      = 8,
  parameter bit          USE_JUMPER = 1'b1,
  parameter logic [21:0] FIXED_BASE = 22'h15AC1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        as_n,
  input  logic        ds0_n,
  input  logic        ds1_n,
  input  logic        write_n,
  input  logic        lword_n,
  input  logic [5:0]  am,
  input  logic [31:1] addr,
  input  logic [31:0] data_in,
  output logic [31:0] data_out,
  output logic        data_oe,
  output logic        dtack_n,
  input  logic        iack_n,
  input  logic        iackin_n,
  output logic        iackout_n,
  output logic [7:1]  irq_n,
  input  logic [21:0] jumper_base,
  input  logic        irq_event
);
  logic        as_s, ds1_s, ds0_s, write_s, iackin_s;
  logic [21:0] base_w;
  space_e      space_w;
  logic        hit_w, d32_w, irq_active_w, iack_match_w;
  logic [3:0]  be_w;
  logic        access_stb, iack_stb;
  logic [2:0]  level_w;
  logic        ien_w, pending_w;

  vme_sync #(.W(5)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({as_n, ds1_n, ds0_n, write_n, iackin_n}),
    .q({as_s, ds1_s, ds0_s, write_s, iackin_s})
  );

  generate
    if (USE_JUMPER) begin : g_jumper
      assign base_w = jumper_base;
    end else begin : g_fixed
      assign base_w = FIXED_BASE;
    end
  endgenerate

  assign space_w      = am_space(am);
  assign hit_w        = base_hit(space_w, addr[31:10], base_w);
  assign d32_w        = !lword_n && !ds0_n && !ds1_n;
  assign be_w         = lane_enables(d32_w, ds1_n, ds0_n, addr[1]);
  assign irq_active_w = pending_w && ien_w && (level_w != 3'd0);
  assign iack_match_w = irq_active_w && (addr[3:1] == level_w);

  vme_cycle_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .as_s(as_s), .ds0_s(ds0_s), .ds1_s(ds1_s), .write_s(write_s),
    .iackin_s(iackin_s), .iack_n(iack_n),
    .hit(hit_w), .iack_match(iack_match_w),
    .access_stb(access_stb), .iack_stb(iack_stb),
    .dtack_n(dtack_n), .iackout_n(iackout_n), .data_oe(data_oe)
  );

  vme_regfile #(.NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .access_stb(access_stb), .iack_stb(iack_stb), .wr_en(!write_s),
    .word_idx(addr[9:2]), .be(be_w), .wdata(spread_write(data_in, d32_w)),
    .d32(d32_w), .a1(addr[1]), .irq_event(irq_event),
    .rdata(data_out), .level(level_w), .ien(ien_w), .pending(pending_w)
  );

  generate
    for (genvar g = 1; g <= 7; g++) begin : g_irq
      assign irq_n[g] = !(irq_active_w && (level_w == 3'(g)));
    end
  endgenerate
endmodule

// File: rtl/vme_reg_slave_checker.sv
module vme_reg_slave_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       dtack_n,
  input logic       data_oe,
  input logic       iackout_n,
  input logic       ds0_n,
  input logic       ds1_n,
  input logic       ien,
  input logic       pending,
  input logic       access_stb,
  input logic       irq_event,
  input logic [7:1] irq_n
);
  assert_dtack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && (!ds0_n || !ds1_n)) |=> !dtack_n);

  assert_oe_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !dtack_n);

  assert_ack_or_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !iackout_n));

  assert_one_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~irq_n) <= 1);

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n != 7'h7F) |-> (ien && pending));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (access_stb && !irq_event) |=> !pending);

  assert_event_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> pending);
endmodule

bind vme_reg_slave vme_reg_slave_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dtack_n(dtack_n), .data_oe(data_oe),
  .iackout_n(iackout_n), .ds0_n(ds0_n), .ds1_n(ds1_n), .ien(ien_w),
  .pending(pending_w), .access_stb(access_stb), .irq_event(irq_event),
  .irq_n(irq_n)
);

// File: tb/vme_reg_slave_bench.sv
module vme_reg_slave_bench;
  localparam logic [21:0] JB = 22'h2A53C;
  localparam logic [21:0] FB = 22'h15AC1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic as_n = 1, ds0_n = 1, ds1_n = 1, write_n = 1, lword_n = 1;
  logic iack_n = 1, iackin_n = 1, irq_event = 0;
  logic [5:0]  am = '0;
  logic [31:1] addr = '0;
  logic [31:0] data_in = '0;
  logic [31:0] dout_a, dout_b;
  logic oe_a, oe_b, dtack_a, dtack_b, io_a, io_b;
  logic [7:1] irq_a, irq_b;

  int checks = 0, failures = 0, cycles = 0;
  logic ack_a, ack_b, io_seen, rel_ok;
  int lat;
  logic [31:0] rd_a, rd_b;

  always #5 clk = ~clk;

  vme_reg_slave #(.NREGS(8), .USE_JUMPER(1'b1)) u_vme_reg_slave (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds0_n(ds0_n), .ds1_n(ds1_n),
    .write_n(write_n), .lword_n(lword_n), .am(am), .addr(addr), .data_in(data_in),
    .data_out(dout_a), .data_oe(oe_a), .dtack_n(dtack_a), .iack_n(iack_n),
    .iackin_n(iackin_n), .iackout_n(io_a), .irq_n(irq_a), .jumper_base(JB),
    .irq_event(irq_event));

  vme_reg_slave #(.NREGS(8), .USE_JUMPER(1'b0), .FIXED_BASE(FB)) u_vme_reg_slave_fixed (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds0_n(ds0_n), .ds1_n(ds1_n),
    .write_n(write_n), .lword_n(lword_n), .am(am), .addr(addr), .data_in(data_in),
    .data_out(dout_b), .data_oe(oe_b), .dtack_n(dtack_b), .iack_n(iack_n),
    .iackin_n(iackin_n), .iackout_n(io_b), .irq_n(irq_b), .jumper_base(JB),
    .irq_event(irq_event));

  task automatic check(input logic ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog got=%0d exp=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int am_class(input logic [5:0] c);
    if (c == 6'h09 || c == 6'h0D) return 0;
    if (c == 6'h39 || c == 6'h3D) return 1;
    if (c == 6'h29 || c == 6'h2D) return 2;
    return -1;
  endfunction

  function automatic logic [5:0] am_of(input int sp);
    return (sp == 0) ? 6'h09 : (sp == 1) ? 6'h3D : 6'h2D;
  endfunction

  function automatic logic [31:1] mk(input int sp, input logic [21:0] b,
                                     input int word, input logic a1);
    if (sp == 0) return {b, 8'(word), a1};
    if (sp == 1) return {8'h00, b[13:0], 8'(word), a1};
    return {16'h0000, b[5:0], 8'(word), a1};
  endfunction

  // One bus cycle. s1/s0 = strobe asserted. ev = event pulse on the access edge.
  task automatic cyc(input logic [5:0] c, input logic [31:1] a, input logic d32,
                     input logic s1, input logic s0, input logic wr,
                     input logic [31:0] wd, input logic iack, input logic iin,
                     input logic ev);
    @(negedge clk);
    am = c; addr = a; lword_n = !d32; write_n = !wr; data_in = wd;
    iack_n = !iack; iackin_n = !iin; as_n = 0; ds1_n = !s1; ds0_n = !s0;
    ack_a = 0; ack_b = 0; io_seen = 0; lat = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i == 2) irq_event = ev;
      if (i == 3) irq_event = 0;
      if (!ack_a && !dtack_a) begin ack_a = 1; lat = i; rd_a = dout_a; end
      if (!ack_b && !dtack_b) begin ack_b = 1; lat = i; rd_b = dout_b; end
      if (!io_a) io_seen = 1;
    end
    as_n = 1; ds1_n = 1; ds0_n = 1; iack_n = 1; iackin_n = 1;
    for (int i = 0; i < 6; i++) @(negedge clk);
    rel_ok = dtack_a && dtack_b && io_a;
  endtask

  task automatic wr32(input int sp, input logic [21:0] b, input int w, input logic [31:0] v);
    cyc(am_of(sp), mk(sp, b, w, 1'b0), 1, 1, 1, 1, v, 0, 0, 0);
  endtask

  task automatic rd32(input int sp, input logic [21:0] b, input int w);
    cyc(am_of(sp), mk(sp, b, w, 1'b0), 1, 1, 1, 0, 32'h0, 0, 0, 0);
  endtask

  task automatic pulse;
    @(negedge clk); irq_event = 1;
    @(negedge clk); irq_event = 0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    logic [31:0] last, exp, sid;
    logic [7:1] exp_irq;
    int wl;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Reset state
    check(dtack_a && io_a && !oe_a, "R6 reset strobes", {dtack_a, io_a, oe_a}, 3'b110);
    check(irq_a == 7'h7F, "R8 reset irq", 32'(irq_a), 32'h7F);
    rd32(0, JB, 0);
    check(ack_a && rd_a == 32'h0, "R7 reset ctrl", rd_a, 0);

    // R1/R2: sweep all modifier codes
    wr32(0, JB, 2, 32'h5555_0000); last = 32'h5555_0000;
    for (int c = 0; c < 64; c++) begin
      int sp;
      logic [31:0] v;
      sp = am_class(6'(c));
      v = 32'h1000 + c;
      cyc(6'(c), mk(sp < 0 ? 0 : sp, JB, 2, 1'b0), 1, 1, 1, 1, v, 0, 0, 0);
      check(ack_a == (sp >= 0), "R1 ack per code", {ack_a, 26'h0, 6'(c)}, {(sp >= 0), 26'h0, 6'(c)});
      if (ack_a) begin
        check(lat <= 5 && lat >= 1, "R6 latency", lat, 5);
        last = v;
      end
      check(rel_ok, "R6 release", {31'h0, rel_ok}, 1);
      rd32(0, JB, 2);
      check(rd_a == last, "R1 no effect of ignored code", rd_a, last);
    end

    // R2: single-bit base mismatch in each space
    for (int sp = 0; sp < 3; sp++) begin
      int nb;
      nb = (sp == 0) ? 22 : (sp == 1) ? 14 : 6;
      rd32(sp, JB, 2);
      check(ack_a && rd_a == last, "R2 match", rd_a, last);
      for (int b = 0; b < nb; b++) begin
        rd32(sp, JB ^ (22'h1 << b), 2);
        check(!ack_a, "R2 base mismatch", {31'h0, ack_a}, 0);
      end
    end

    // R3: fixed-base instance
    wr32(0, FB, 2, 32'hF1F2_F3F4);
    check(ack_b && !ack_a, "R3 fixed base write", {ack_a, ack_b}, 2'b01);
    rd32(0, FB, 2);
    check(ack_b && rd_b == 32'hF1F2_F3F4, "R3 fixed base read", rd_b, 32'hF1F2_F3F4);
    rd32(0, JB, 2);
    check(!ack_b, "R3 jumper ignored", {31'h0, ack_b}, 0);

    // R4: 32-bit access
    wr32(1, JB, 3, 32'hDEAD_BEEF);
    rd32(2, JB, 3);
    check(rd_a == 32'hDEAD_BEEF, "R4 d32 round trip", rd_a, 32'hDEAD_BEEF);

    // R5: lane sweep
    for (int a1 = 0; a1 < 2; a1++)
      for (int p = 1; p < 4; p++) begin
        wr32(0, JB, 3, 32'h1122_3344);
        cyc(6'h09, mk(0, JB, 3, 1'(a1)), 0, p[1], p[0], 1, 32'h0000_A5C3, 0, 0, 0);
        exp = 32'h1122_3344;
        if (a1 == 0) begin
          if (p[1]) exp[31:24] = 8'hA5;
          if (p[0]) exp[23:16] = 8'hC3;
        end else begin
          if (p[1]) exp[15:8] = 8'hA5;
          if (p[0]) exp[7:0] = 8'hC3;
        end
        rd32(0, JB, 3);
        check(rd_a == exp, "R5 lane write", rd_a, exp);
        cyc(6'h09, mk(0, JB, 3, 1'(a1)), 0, 1, 1, 0, 32'h0, 0, 0, 0);
        check(rd_a == (a1 == 1 ? {16'h0, exp[15:0]} : {16'h0, exp[31:16]}), "R5 half read",
              rd_a, a1 == 1 ? {16'h0, exp[15:0]} : {16'h0, exp[31:16]});
      end

    // R7: register map
    wr32(0, JB, 0, 32'hFFFF_FFFF);
    rd32(0, JB, 0);
    check(rd_a == 32'h0000_000F, "R7 ctrl mask", rd_a, 32'hF);
    wr32(0, JB, 0, 32'h0);
    wr32(0, JB, 200, 32'hABCD_0123);
    check(ack_a, "R7 high word acked", {31'h0, ack_a}, 1);
    rd32(0, JB, 200);
    check(ack_a && rd_a == 32'h0, "R7 high word reads zero", rd_a, 0);

    // R8/R9/R10 per level
    for (int l = 1; l <= 7; l++) begin
      sid = 32'hC0DE_0000 | l;
      wr32(0, JB, 1, sid);
      wr32(0, JB, 0, 32'(8 | l));
      pulse();
      exp_irq = ~(7'h1 << (l - 1));
      check(irq_a == exp_irq, "R8 level line", 32'(irq_a), 32'(exp_irq));
      wl = (l % 7) + 1;
      cyc(6'h09, 31'(wl), 1, 1, 1, 0, 0, 1, 1, 0);
      check(!ack_a && io_seen, "R9 wrong level passes", {ack_a, io_seen}, 2'b01);
      cyc(6'h09, 31'(l), 1, 1, 1, 0, 0, 1, 0, 0);
      check(!ack_a && !io_seen, "R9 no chain input", {ack_a, io_seen}, 2'b00);
      cyc(6'h09, 31'(l), 1, 1, 1, 0, 0, 1, 1, 0);
      check(ack_a && rd_a == sid && !io_seen, "R9 status id", rd_a, sid);
      check(irq_a == exp_irq, "R10 iack keeps request", 32'(irq_a), 32'(exp_irq));
      rd32(0, JB, 0);
      check(rd_a == (32'h8000_0008 | l), "R10 pending read", rd_a, 32'h8000_0008 | l);
      check(irq_a == 7'h7F, "R10 released by access", 32'(irq_a), 32'h7F);
    end

    // R8: enable off and level 0
    wr32(0, JB, 0, 32'h3);
    pulse();
    check(irq_a == 7'h7F, "R8 disabled", 32'(irq_a), 32'h7F);
    wr32(0, JB, 0, 32'h8);
    pulse();
    check(irq_a == 7'h7F, "R8 level zero", 32'(irq_a), 32'h7F);
    rd32(0, JB, 0);

    // R10: event and access on the same edge
    wr32(0, JB, 0, 32'hD);
    pulse();
    check(irq_a == 7'h6F, "R10 raised", 32'(irq_a), 32'h6F);
    cyc(6'h09, mk(0, JB, 2, 1'b0), 1, 1, 1, 1, 32'h77, 0, 0, 1);
    check(ack_a && irq_a == 7'h6F, "R10 event wins over clear", 32'(irq_a), 32'h6F);
    wr32(0, JB, 2, 32'h78);
    check(irq_a == 7'h7F, "R10 cleared", 32'(irq_a), 32'h7F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule